// File: doc/BRIEF.md
# Snooping Write-Through Invalidate Cache Controller

This block is the private first-level cache controller of one processor on a small multiprocessor. All processors share one arbitrated bus to main memory. The cache is direct-mapped and keeps one bit of coherence state per block, valid or not valid. Every processor store is sent to memory over the bus. A store that finds its block present also updates the cached copy. A store that misses leaves the cache alone.

A load that misses requests the bus and waits for a grant. It then issues one whole-block read and fills the line from the returned block. The requested word goes back to the processor in the same cycle as the bus completion. A load that hits answers in the cycle it is presented.

A second tag read port watches every transaction on the shared bus. A write from another agent that matches a held block clears that block's valid bit. This snoop path never stalls the processor. A snoop kill and a processor load hit on the same line in the same cycle resolve in favour of the snoop, and the load is then served as a miss.

Top module: `wtc_snoop_cache`

## Requirements
- R1: After reset every line is invalid: `cpu_ready`, `bus_req` and `m_valid` are low, and the first load of any address raises `bus_req`.
- R2: A load whose block is valid with a matching tag asserts `cpu_ready` in the cycle it is presented, with the cached word on `cpu_rdata`, and uses no bus cycle.
- R3: A load miss holds `bus_req` until `bus_done`. In the first granted cycle it drives a one-cycle `m_valid` with `m_we`=0, `m_id` equal to the parameter `MY_ID`, and `m_addr` equal to the address with its low 4 bits cleared. On `bus_done` it fills the line from `bus_rdata`, where word w occupies bits [32w+31:32w], and returns the requested word.
- R4: Every store, hit or miss, issues exactly one bus write: `m_we`=1, `m_addr` set to the word address, `m_wdata` set to the store data. `cpu_ready` for a store rises only together with `bus_done`.
- R5: A store hit updates the cached word. A later load of that word hits and returns the stored data.
- R6: A store miss does not allocate. A later load of that address misses and fetches the stored data from memory.
- R7: A snooped write (`snp_valid`=1, `snp_we`=1) from an id other than `MY_ID` to a held block invalidates the line. The next load of any word in that block misses.
- R8: Snooped transactions whose id equals `MY_ID`, and snooped reads, leave the cache contents unchanged.
- R9: When a snoop kill and a processor load to the same line fall in the same cycle, `cpu_ready` stays low in that cycle, and the load completes through a bus read.
- R10: `m_valid` is asserted only while `bus_gnt` is high, and never for two cycles in a row.
- R11: A snooped foreign write whose index matches a held line but whose tag differs leaves that line valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant, held until `bus_done` |
| m_valid | output | 1 | Transaction issue strobe |
| m_we | output | 1 | Issued transaction is a write |
| m_addr | output | 32 | Issued address (block base for reads, word address for writes) |
| m_wdata | output | 32 | Issued write data |
| m_id | output | 2 | Requester id of this cache |
| snp_valid | input | 1 | A transaction is on the shared bus |
| snp_we | input | 1 | Observed transaction is a write |
| snp_addr | input | 32 | Observed address |
| snp_id | input | 2 | Observed requester id |
| bus_done | input | 1 | Current bus transaction completes |
| bus_rdata | input | 128 | Block returned with `bus_done` |

## Verification
The assertions take the processor request fields as stable from `cpu_valid` until `cpu_ready`. They also take `bus_gnt` as given only while this cache requests, `bus_done` as ending a transaction that was actually started, and only one transaction on the bus at a time. The bench keeps within these rules because it acts as the only arbiter and memory. It starts a foreign transaction only when the bus is idle and no grant is pending. It grants only when no transaction is in flight, and it keeps each processor request steady until it completes. The one deliberate overlap is the R9 case, where the foreign write and the processor load start in the same cycle and the arbiter holds the grant back until the foreign write completes.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    WTC_IDLE = 2'd0,
    WTC_REQ  = 2'd1,
    WTC_WAIT = 2'd2
  } wtc_state_e;

  // Extract a w-bit field starting at bit lo.
  function automatic logic [63:0] wtc_field(input logic [63:0] a,
                                            input int unsigned lo,
                                            input int unsigned w);
    logic [63:0] mask;
    mask = (64'd1 << w) - 64'd1;
    return (a >> lo) & mask;
  endfunction

  // Clear the low lo bits (block base or word alignment).
  function automatic logic [63:0] wtc_align(input logic [63:0] a,
                                            input int unsigned lo);
    return (a >> lo) << lo;
  endfunction

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int LINES    = 16,
  parameter int IDX_BITS = 4,
  parameter int TAG_BITS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_BITS-1:0] p_idx,
  output logic                p_valid,
  output logic [TAG_BITS-1:0] p_tag,
  input  logic [IDX_BITS-1:0] s_idx,
  output logic                s_valid,
  output logic [TAG_BITS-1:0] s_tag,
  input  logic                fill_en,
  input  logic [IDX_BITS-1:0] fill_idx,
  input  logic [TAG_BITS-1:0] fill_tag,
  input  logic                inv_en,
  input  logic [IDX_BITS-1:0] inv_idx
);

  logic [LINES-1:0]    valid_q;
  logic [TAG_BITS-1:0] tag_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
      end else if (fill_en && fill_idx == IDX_BITS'(i)) begin
        valid_q[i] <= 1'b1;
      end else if (inv_en && inv_idx == IDX_BITS'(i)) begin
        valid_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  // Processor port and snoop port read independently.
  assign p_valid = valid_q[p_idx];
  assign p_tag   = tag_q[p_idx];
  assign s_valid = valid_q[s_idx];
  assign s_tag   = tag_q[s_idx];

endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int LINES     = 16,
  parameter int WORDS     = 4,
  parameter int DW        = 32,
  parameter int IDX_BITS  = 4,
  parameter int WOFF_BITS = 2
) (
  input  logic                   clk,
  input  logic [IDX_BITS-1:0]    rd_idx,
  input  logic [WOFF_BITS-1:0]   rd_word,
  output logic [DW-1:0]          rd_data,
  input  logic                   blk_we,
  input  logic [IDX_BITS-1:0]    blk_idx,
  input  logic [WORDS*DW-1:0]    blk_data,
  input  logic                   wd_we,
  input  logic [IDX_BITS-1:0]    wd_idx,
  input  logic [WOFF_BITS-1:0]   wd_word,
  input  logic [DW-1:0]          wd_data
);

  logic [WORDS*DW-1:0] line_q [LINES];

  always_ff @(posedge clk) begin
    if (blk_we) begin
      line_q[blk_idx] <= blk_data;
    end else if (wd_we) begin
      line_q[wd_idx][int'(wd_word)*DW +: DW] <= wd_data;
    end
  end

  assign rd_data = line_q[rd_idx][int'(rd_word)*DW +: DW];

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_valid,
  input  logic cpu_we,
  input  logic p_hit,
  input  logic snoop_kill,
  input  logic bus_gnt,
  input  logic bus_done,
  output logic bus_req,
  output logic issue,
  output logic ready_hit,
  output logic ready_bus,
  output logic fill_en,
  output logic wword_en,
  output logic is_idle
);

  wtc_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    bus_req   = 1'b0;
    issue     = 1'b0;
    ready_hit = 1'b0;
    ready_bus = 1'b0;
    fill_en   = 1'b0;
    wword_en  = 1'b0;
    unique case (state_q)
      WTC_IDLE: begin
        if (cpu_valid) begin
          if (!cpu_we && p_hit && !snoop_kill) ready_hit = 1'b1;
          else                                 state_d   = WTC_REQ;
        end
      end
      WTC_REQ: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          issue   = 1'b1;
          state_d = WTC_WAIT;
        end
      end
      WTC_WAIT: begin
        bus_req = 1'b1;
        if (bus_done) begin
          ready_bus = 1'b1;
          fill_en   = !cpu_we;
          wword_en  = cpu_we && p_hit && !snoop_kill;
          state_d   = WTC_IDLE;
        end
      end
      default: state_d = WTC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= WTC_IDLE;
    else        state_q <= state_d;
  end

  assign is_idle = (state_q == WTC_IDLE);

endmodule

// File: rtl/wtc_snoop_cache.sv
module wtc_snoop_cache
  import wtc_pkg::*;
#(
  parameter int          LINES = 16,
  parameter int          WORDS = 4,
  parameter int          DW    = 32,
  parameter int          AW    = 32,
  parameter int          ID_W  = 2,
  parameter logic [1:0]  MY_ID = 2'd2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_valid,
  input  logic                cpu_we,
  input  logic [AW-1:0]       cpu_addr,
  input  logic [DW-1:0]       cpu_wdata,
  output logic                cpu_ready,
  output logic [DW-1:0]       cpu_rdata,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic                m_valid,
  output logic                m_we,
  output logic [AW-1:0]       m_addr,
  output logic [DW-1:0]       m_wdata,
  output logic [ID_W-1:0]     m_id,
  input  logic                snp_valid,
  input  logic                snp_we,
  input  logic [AW-1:0]       snp_addr,
  input  logic [ID_W-1:0]     snp_id,
  input  logic                bus_done,
  input  logic [WORDS*DW-1:0] bus_rdata
);

  localparam int BYTE_BITS = $clog2(DW / 8);
  localparam int WOFF_BITS = $clog2(WORDS);
  localparam int OFF_BITS  = BYTE_BITS + WOFF_BITS;
  localparam int IDX_BITS  = $clog2(LINES);
  localparam int TAG_BITS  = AW - OFF_BITS - IDX_BITS;
  localparam logic [ID_W-1:0] OWN_ID = ID_W'(MY_ID);

  // Address decode via package functions
  logic [63:0] cpu_a64, snp_a64;
  logic [63:0] f_cidx, f_ctag, f_cword, f_sidx, f_stag, f_base, f_waddr;
  assign cpu_a64 = 64'(cpu_addr);
  assign snp_a64 = 64'(snp_addr);
  assign f_cidx  = wtc_field(cpu_a64, OFF_BITS, IDX_BITS);
  assign f_ctag  = wtc_field(cpu_a64, OFF_BITS + IDX_BITS, TAG_BITS);
  assign f_cword = wtc_field(cpu_a64, BYTE_BITS, WOFF_BITS);
  assign f_sidx  = wtc_field(snp_a64, OFF_BITS, IDX_BITS);
  assign f_stag  = wtc_field(snp_a64, OFF_BITS + IDX_BITS, TAG_BITS);
  assign f_base  = wtc_align(cpu_a64, OFF_BITS);
  assign f_waddr = wtc_align(cpu_a64, BYTE_BITS);

  logic [IDX_BITS-1:0]  c_idx, s_idx;
  logic [TAG_BITS-1:0]  c_tag, s_tagin;
  logic [WOFF_BITS-1:0] c_word;
  assign c_idx   = f_cidx[IDX_BITS-1:0];
  assign c_tag   = f_ctag[TAG_BITS-1:0];
  assign c_word  = f_cword[WOFF_BITS-1:0];
  assign s_idx   = f_sidx[IDX_BITS-1:0];
  assign s_tagin = f_stag[TAG_BITS-1:0];

  // Tag store: processor port + snoop port
  logic                p_valid, s_valid;
  logic [TAG_BITS-1:0] p_tag, s_tag;
  logic                p_hit;

  // Named internal events (observed by the checker)
  logic ev_snoop_inv;
  logic ev_race;
  logic ev_fill;
  logic snoop_kill;

  logic issue, ready_hit, ready_bus, wword_en, ctl_idle;

  assign p_hit        = p_valid && (p_tag == c_tag);
  assign ev_snoop_inv = snp_valid && snp_we && (snp_id != OWN_ID) &&
                        s_valid && (s_tag == s_tagin);
  assign snoop_kill   = ev_snoop_inv && (s_idx == c_idx);
  assign ev_race      = cpu_valid && !cpu_we && ctl_idle && p_hit && snoop_kill;

  wtc_tag_store #(
    .LINES(LINES), .IDX_BITS(IDX_BITS), .TAG_BITS(TAG_BITS)
  ) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .p_idx    (c_idx),
    .p_valid  (p_valid),
    .p_tag    (p_tag),
    .s_idx    (s_idx),
    .s_valid  (s_valid),
    .s_tag    (s_tag),
    .fill_en  (ev_fill),
    .fill_idx (c_idx),
    .fill_tag (c_tag),
    .inv_en   (ev_snoop_inv),
    .inv_idx  (s_idx)
  );

  logic [DW-1:0] arr_word, bus_word;

  wtc_data_store #(
    .LINES(LINES), .WORDS(WORDS), .DW(DW),
    .IDX_BITS(IDX_BITS), .WOFF_BITS(WOFF_BITS)
  ) u_data (
    .clk      (clk),
    .rd_idx   (c_idx),
    .rd_word  (c_word),
    .rd_data  (arr_word),
    .blk_we   (ev_fill),
    .blk_idx  (c_idx),
    .blk_data (bus_rdata),
    .wd_we    (wword_en),
    .wd_idx   (c_idx),
    .wd_word  (c_word),
    .wd_data  (cpu_wdata)
  );

  wtc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_we     (cpu_we),
    .p_hit      (p_hit),
    .snoop_kill (snoop_kill),
    .bus_gnt    (bus_gnt),
    .bus_done   (bus_done),
    .bus_req    (bus_req),
    .issue      (issue),
    .ready_hit  (ready_hit),
    .ready_bus  (ready_bus),
    .fill_en    (ev_fill),
    .wword_en   (wword_en),
    .is_idle    (ctl_idle)
  );

  assign bus_word  = bus_rdata[int'(c_word)*DW +: DW];
  assign cpu_ready = ready_hit || ready_bus;
  assign cpu_rdata = ready_bus ? bus_word : arr_word;

  // Bus issue side
  assign m_valid = issue;
  assign m_we    = issue && cpu_we;
  assign m_addr  = issue ? (cpu_we ? f_waddr[AW-1:0] : f_base[AW-1:0]) : '0;
  assign m_wdata = (issue && cpu_we) ? cpu_wdata : '0;
  assign m_id    = OWN_ID;

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int         ID_W  = 2,
  parameter logic [1:0] MY_ID = 2'd2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_we,
  input logic            cpu_ready,
  input logic            bus_req,
  input logic            bus_gnt,
  input logic            bus_done,
  input logic            m_valid,
  input logic [ID_W-1:0] m_id,
  input logic            snp_valid,
  input logic            snp_we,
  input logic [ID_W-1:0] snp_id,
  input logic            ev_snoop_inv,
  input logic            ev_race,
  input logic            ev_fill
);

  p_issue_needs_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> bus_gnt);

  p_issue_one_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |=> !m_valid);

  p_issue_own_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_id == ID_W'(MY_ID)));

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> bus_req);

  p_fill_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |-> (bus_done && !cpu_we));

  p_store_waits_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |-> bus_done);

  p_race_is_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_race |-> !cpu_ready);

  p_own_id_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_id == ID_W'(MY_ID)) |-> !ev_snoop_inv);

  p_snoop_read_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_we) |-> !ev_snoop_inv);

endmodule

bind wtc_snoop_cache wtc_checker #(.ID_W(ID_W), .MY_ID(MY_ID)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_we       (cpu_we),
  .cpu_ready    (cpu_ready),
  .bus_req      (bus_req),
  .bus_gnt      (bus_gnt),
  .bus_done     (bus_done),
  .m_valid      (m_valid),
  .m_id         (m_id),
  .snp_valid    (snp_valid),
  .snp_we       (snp_we),
  .snp_id       (snp_id),
  .ev_snoop_inv (ev_snoop_inv),
  .ev_race      (ev_race),
  .ev_fill      (ev_fill)
);

// File: tb/wtc_snoop_cache_tb.sv
`timescale 1ns/100ps
module wtc_snoop_cache_tb;

  localparam logic [1:0] OWN = 2'd2;
  localparam logic [1:0] OTHER = 2'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         cpu_valid = 0, cpu_we = 0;
  logic [31:0]  cpu_addr = 0, cpu_wdata = 0;
  logic         cpu_ready;
  logic [31:0]  cpu_rdata;
  logic         bus_req, bus_gnt;
  logic         m_valid, m_we;
  logic [31:0]  m_addr, m_wdata;
  logic [1:0]   m_id;
  logic         f_valid = 0, f_we = 0;
  logic [31:0]  f_addr = 0, f_wdata = 0;
  logic [1:0]   f_id = 0;
  logic         snp_valid, snp_we;
  logic [31:0]  snp_addr, snp_wdata;
  logic [1:0]   snp_id;
  logic         bus_done;
  logic [127:0] bus_rdata;

  assign snp_valid = m_valid | f_valid;
  assign snp_we    = m_valid ? m_we    : f_we;
  assign snp_addr  = m_valid ? m_addr  : f_addr;
  assign snp_wdata = m_valid ? m_wdata : f_wdata;
  assign snp_id    = m_valid ? m_id    : f_id;

  wtc_snoop_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_id(m_id),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr), .snp_id(snp_id),
    .bus_done(bus_done), .bus_rdata(bus_rdata)
  );

  // Memory model: 1024 words, completion two cycles after issue
  logic [31:0] mem [1024];
  int          cnt;
  logic        p_we;
  logic [31:0] p_addr, p_data;

  function automatic logic [31:0] init_val(input int i);
    return 32'hC0DE_0000 ^ (32'(i) * 32'h0001_0101);
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = init_val(i);
  end

  always @(posedge clk) begin
    bus_done <= 1'b0;
    if (!rst_n) begin
      cnt <= 0;
      bus_rdata <= '0;
    end else if (snp_valid) begin
      cnt <= 2; p_we <= snp_we; p_addr <= snp_addr; p_data <= snp_wdata;
    end else if (cnt == 1) begin
      cnt <= 0;
      bus_done <= 1'b1;
      if (p_we) mem[p_addr[11:2]] <= p_data;
      for (int w = 0; w < 4; w++)
        bus_rdata[w*32 +: 32] <= mem[{p_addr[11:4], 2'(w)}];
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end
  end

  // Arbiter: one transaction at a time, grant held until completion
  always @(posedge clk) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else if (bus_gnt && bus_done) bus_gnt <= 1'b0;
    else if (!bus_gnt && bus_req && cnt == 0 && !f_valid && !bus_done) bus_gnt <= 1'b1;
  end

  // Bus monitor for this cache's issues
  int          n_tx;
  bit          saw_req;
  logic        t_we;
  logic [31:0] t_addr, t_data;
  logic [1:0]  t_id;
  always @(posedge clk) begin
    if (bus_req) saw_req = 1;
    if (m_valid) begin
      n_tx++; t_we = m_we; t_addr = m_addr; t_data = m_wdata; t_id = m_id;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output bit used_bus);
    @(negedge clk);
    n_tx = 0; saw_req = 0;
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_valid = 0;
    used_bus = saw_req || (n_tx != 0);
  endtask

  task automatic foreign(input bit we, input logic [31:0] a, input logic [31:0] d,
                         input logic [1:0] id);
    @(negedge clk);
    while (bus_gnt || cnt != 0) @(negedge clk);
    f_valid = 1; f_we = we; f_addr = a; f_wdata = d; f_id = id;
    @(negedge clk);
    f_valid = 0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] mword(input logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd, old;
    bit          ub;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready after reset", 32'(cpu_ready), 0);
    chk("R1 req after reset",   32'(bus_req),   0);
    chk("R1 issue after reset", 32'(m_valid),   0);
    rst_n = 1;

    // R1/R3: cold misses across every line
    for (int ln = 0; ln < 16; ln++) begin
      logic [31:0] a;
      a = 32'h400 + 32'(ln) * 16 + 32'(ln % 4) * 4;
      cpu_op(0, a, 0, rd, ub);
      chk("R1 cold load uses bus", 32'(ub), 1);
      chk("R3 fill data", rd, mword(a));
      chk("R3 read is block base", t_addr, a & ~32'hF);
      chk("R3 read not write", 32'(t_we), 0);
      chk("R3 own id", 32'(t_id), 32'(OWN));
      chk("R3 one issue", n_tx, 1);
    end

    // R2: every word of every line now hits
    for (int ln = 0; ln < 16; ln++) begin
      for (int w = 0; w < 4; w++) begin
        logic [31:0] a;
        a = 32'h400 + 32'(ln) * 16 + 32'(w) * 4;
        cpu_op(0, a, 0, rd, ub);
        chk("R2 hit no bus", 32'(ub), 0);
        chk("R2 hit data", rd, mword(a));
      end
    end

    // R4/R5: store hit
    cpu_op(1, 32'h458, 32'hDEAD_0001, rd, ub);
    chk("R4 store hit issues one", n_tx, 1);
    chk("R4 store is write", 32'(t_we), 1);
    chk("R4 store word address", t_addr, 32'h458);
    chk("R4 store data", t_data, 32'hDEAD_0001);
    chk("R4 memory updated", mword(32'h458), 32'hDEAD_0001);
    cpu_op(0, 32'h458, 0, rd, ub);
    chk("R5 load after store hit no bus", 32'(ub), 0);
    chk("R5 load after store hit data", rd, 32'hDEAD_0001);

    // R6: store miss, no allocate (index 3, other tag than 0x430)
    cpu_op(1, 32'h834, 32'hBEEF_0006, rd, ub);
    chk("R4 store miss issues one", n_tx, 1);
    chk("R4 store miss address", t_addr, 32'h834);
    cpu_op(0, 32'h834, 0, rd, ub);
    chk("R6 load after store miss uses bus", 32'(ub), 1);
    chk("R6 load after store miss data", rd, 32'hBEEF_0006);

    // R7: foreign write to held block (line 6) invalidates
    foreign(1, 32'h464, 32'h7777_0007, OTHER);
    cpu_op(0, 32'h468, 0, rd, ub);
    chk("R7 other word misses", 32'(ub), 1);
    chk("R7 refill data", rd, mword(32'h468));
    cpu_op(0, 32'h464, 0, rd, ub);
    chk("R7 written word hits after refill", 32'(ub), 0);
    chk("R7 written word data", rd, 32'h7777_0007);

    // R8: own-id write and foreign read are ignored
    cpu_op(0, 32'h474, 0, old, ub);
    foreign(1, 32'h474, 32'h8888_0008, OWN);
    cpu_op(0, 32'h474, 0, rd, ub);
    chk("R8 own id keeps line", 32'(ub), 0);
    chk("R8 own id keeps data", rd, old);
    foreign(0, 32'h480, 0, OTHER);
    cpu_op(0, 32'h480, 0, rd, ub);
    chk("R8 snoop read keeps line", 32'(ub), 0);
    chk("R8 snoop read data", rd, mword(32'h480));

    // R11: same index, different tag
    foreign(1, 32'h894, 32'h1111_0011, OTHER);
    cpu_op(0, 32'h494, 0, rd, ub);
    chk("R11 other tag keeps line", 32'(ub), 0);
    chk("R11 other tag data", rd, mword(32'h494));

    // R9: snoop kill and load hit in the same cycle (line 10)
    cpu_op(0, 32'h4A4, 0, rd, ub);
    chk("R9 setup hit", 32'(ub), 0);
    @(negedge clk);
    n_tx = 0; saw_req = 0;
    f_valid = 1; f_we = 1; f_addr = 32'h4A4; f_wdata = 32'h9999_0009; f_id = OTHER;
    cpu_valid = 1; cpu_we = 0; cpu_addr = 32'h4A4;
    #1;
    chk("R9 no ready on race", 32'(cpu_ready), 0);
    @(negedge clk);
    f_valid = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_valid = 0;
    chk("R9 replayed through bus", n_tx, 1);
    chk("R9 replay data", rd, 32'h9999_0009);

    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule